// File: doc/BRIEF.md
# Hash DMA Fetch Engine

This block moves a message out of memory and into a hash core. When a start strobe arrives while it is idle, it captures a source address and a byte count. The source address is rounded down to a word boundary. The block then walks memory one 32-bit word at a time over a simple request/response bus. Each returned word goes to a downstream ready/valid sink, together with a per-byte valid mask. The final word carries a last marker, and its mask covers only the bytes that belong to the message.

A byte count of zero produces a single empty, last-marked beat and no memory reads. A stop strobe aborts a running transfer. So does an error response from the bus, which also raises a sticky error flag; the flag clears only on the next accepted start. Because address and count are captured at start, the inputs may change for the next job while the current one runs.

The controller is one state machine with five states:
- `ST_IDLE` waits for start.
- `ST_ISSUE` drives a read request.
- `ST_AWAIT` waits for the response.
- `ST_DELIVER` offers the fetched word to the sink.
- `ST_NULL` offers the empty beat of a zero-length job.

The transitions are:
- start (idle → issue, or idle → null when the count is zero)
- request accepted (issue → await)
- good response (await → deliver)
- error response (await → idle)
- word accepted with more to come (deliver → issue)
- final word accepted (deliver → idle)
- empty beat accepted (null → idle)
- stop (any busy state → idle)

Top module: `hash_dma_fetch`

## Requirements
- R1: After reset, `busy`, `dma_err`, `mem_req_valid` and `out_valid` are all 0.
- R2: The first read address is `src_addr` with bits 1:0 forced to 0. Each later read is 4 higher than the one before.
- R3: A job with byte count N issues exactly ceil(N/4) reads. Every beat except the last has `out_mask` = 4'b1111.
- R4: The last beat of a non-empty job has `out_last` = 1. Bit i of `out_mask` marks byte i (bits 7:0 are byte 0). The mask has the low (N mod 4) bits set, or all four bits when N mod 4 is 0.
- R5: A zero byte count issues no reads. It presents one beat with `out_last` = 1 and `out_mask` = 4'b0000.
- R6: At most one read is outstanding. No new request is made until the previous word has been accepted by the sink. A presented beat holds its data, mask and marker until it is accepted.
- R7: Changing `src_addr` or `byte_cnt` after start has no effect on the running job.
- R8: `busy` rises in the cycle after an accepted start. It falls in the cycle after the last beat is accepted or the job is aborted. A start while busy is ignored.
- R9: A response with `mem_rsp_err` = 1 ends the job in the next cycle and presents no beat for that word. It sets `dma_err`, which stays 1 until the next accepted start clears it.
- R10: A stop while busy returns the block to idle in the next cycle, with no further requests or beats. A stop while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, taken only when idle |
| stop | input | 1 | Abort strobe |
| src_addr | input | 32 | Message source byte address |
| byte_cnt | input | 32 | Message length in bytes |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word-aligned read address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response word |
| mem_rsp_err | input | 1 | Response carries a bus error |
| out_valid | output | 1 | Beat valid to the hash core |
| out_ready | input | 1 | Hash core accepts the beat |
| out_data | output | 32 | Message word |
| out_mask | output | 4 | Byte-valid mask, bit i for byte i |
| out_last | output | 1 | Final beat of the message |
| busy | output | 1 | Job in progress |
| dma_err | output | 1 | Sticky bus-error flag |

## Verification
Two events can meet in one cycle: an abort strobe and an error response for the outstanding read. The bench provokes this from its memory model, raising stop in exactly the cycle it returns the faulting response. The outcome is judged against the reference model, which expects busy to drop in the next cycle and the error flag to be set in spite of the abort. A second overlap, a stop in the same cycle as a sink handshake, arises from the stop pulses landing on a toggling sink-ready pattern. The model counts the handshake and then expects no further activity.

// File: rtl/hdf_pkg.sv
package hdf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_AWAIT,
        ST_DELIVER,
        ST_NULL
    } fetch_state_t;
endpackage

// File: rtl/hdf_len_calc.sv
module hdf_len_calc #(
    parameter int CNT_W = 32,
    parameter int BYTES = 4,
    localparam int OFF_W = $clog2(BYTES),
    localparam int WRD_W = CNT_W - OFF_W + 1
) (
    input  logic [CNT_W-1:0] byte_cnt,
    output logic [WRD_W-1:0] n_words,
    output logic [BYTES-1:0] tail_mask,
    output logic             zero_len
);
    logic [OFF_W-1:0] rem;

    assign rem      = byte_cnt[OFF_W-1:0];
    assign zero_len = (byte_cnt == '0);
    assign n_words  = WRD_W'(byte_cnt >> OFF_W) + WRD_W'(|rem);

    // Byte i is valid when the remainder reaches past it, or the word is full.
    for (genvar i = 0; i < BYTES; i++) begin : g_tail
        assign tail_mask[i] = (rem == '0) || ({1'b0, rem} > (OFF_W+1)'(i));
    end
endmodule

// File: rtl/hdf_fetch_fsm.sv
module hdf_fetch_fsm
    import hdf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES),
    localparam int WRD_W = CNT_W - OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [WRD_W-1:0]  n_words,
    input  logic [BYTES-1:0]  tail_mask,
    input  logic              zero_len,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [BYTES-1:0]  out_mask,
    output logic              out_last,
    output logic              busy,
    output logic              dma_err
);
    fetch_state_t      state, nxt;
    logic [ADDR_W-1:0] cur_addr;
    logic [WRD_W-1:0]  words_left;
    logic [BYTES-1:0]  tail_q;
    logic [DATA_W-1:0] data_q;
    logic              err_q;
    logic              on_final;

    assign on_final = (words_left == WRD_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = zero_len ? ST_NULL : ST_ISSUE;
            ST_ISSUE:   if (stop) nxt = ST_IDLE;
                        else if (mem_req_ready) nxt = ST_AWAIT;
            ST_AWAIT:   if (stop) nxt = ST_IDLE;
                        else if (mem_rsp_valid) nxt = mem_rsp_err ? ST_IDLE : ST_DELIVER;
            ST_DELIVER: if (stop) nxt = ST_IDLE;
                        else if (out_ready) nxt = on_final ? ST_IDLE : ST_ISSUE;
            ST_NULL:    if (stop || out_ready) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Job registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            words_left <= '0;
            tail_q     <= '0;
            data_q     <= '0;
            err_q      <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                cur_addr   <= {src_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                words_left <= n_words;
                tail_q     <= tail_mask;
                err_q      <= 1'b0;
            end
            if (state == ST_AWAIT && mem_rsp_valid) begin
                if (mem_rsp_err) err_q  <= 1'b1;
                else             data_q <= mem_rsp_data;
            end
            if (state == ST_DELIVER && out_ready && !stop && !on_final) begin
                cur_addr   <= cur_addr + ADDR_W'(BYTES);
                words_left <= words_left - WRD_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req_valid = (state == ST_ISSUE);
        mem_req_addr  = cur_addr;
        out_valid     = (state == ST_DELIVER) || (state == ST_NULL);
        out_data      = data_q;
        out_last      = (state == ST_NULL) || ((state == ST_DELIVER) && on_final);
        if (state == ST_NULL)  out_mask = '0;
        else if (on_final)     out_mask = tail_q;
        else                   out_mask = '1;
        busy          = (state != ST_IDLE);
        dma_err       = err_q;
    end

    // R3: a non-final beat is always full
    p_full_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_last |-> out_mask == {BYTES{1'b1}});

    // R3: an accepted non-final beat leads straight to the next read
    p_next_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last && !stop |=> mem_req_valid);

    // R5: zero-length start gives an empty last beat
    p_empty_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && zero_len |=> out_valid && out_last && out_mask == '0 && !mem_req_valid);

    // R6: pending request holds its address
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready && !stop |=> mem_req_valid && $stable(mem_req_addr));

    // R6: pending beat holds its contents
    p_beat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !stop |=> out_valid && $stable(out_data)
            && $stable(out_mask) && $stable(out_last));

    // R8: accepted start makes the block busy and clears the error
    p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && !dma_err);

    // R9: error response aborts and flags
    p_err_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_AWAIT && mem_rsp_valid && mem_rsp_err |=> dma_err && !busy);

    // R9: the error flag is sticky until a new start
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_err && !(start && !busy) |=> dma_err);

    // R10: stop ends the job in one cycle
    p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && stop |=> !busy && !mem_req_valid && !out_valid);
endmodule

// File: rtl/hash_dma_fetch.sv
module hash_dma_fetch #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES),
    localparam int WRD_W = CNT_W - OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [CNT_W-1:0]  byte_cnt,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [BYTES-1:0]  out_mask,
    output logic              out_last,
    output logic              busy,
    output logic              dma_err
);
    logic [WRD_W-1:0] n_words;
    logic [BYTES-1:0] tail_mask;
    logic             zero_len;

    hdf_len_calc #(.CNT_W(CNT_W), .BYTES(BYTES)) i_len (
        .byte_cnt  (byte_cnt),
        .n_words   (n_words),
        .tail_mask (tail_mask),
        .zero_len  (zero_len)
    );

    hdf_fetch_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .stop          (stop),
        .src_addr      (src_addr),
        .n_words       (n_words),
        .tail_mask     (tail_mask),
        .zero_len      (zero_len),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_err   (mem_rsp_err),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_data      (out_data),
        .out_mask      (out_mask),
        .out_last      (out_last),
        .busy          (busy),
        .dma_err       (dma_err)
    );
endmodule

// File: tb/test_hash_dma_fetch.sv
`timescale 1ns/1ps
module test_hash_dma_fetch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        stop_t = 1'b0;
    logic        stop_drv = 1'b0;
    logic        stop;
    logic [31:0] src_addr = '0;
    logic [31:0] byte_cnt = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic [3:0]  out_mask;
    logic        out_last;
    logic        busy;
    logic        dma_err;

    always #10 clk = ~clk;
    assign stop = stop_t | stop_drv;

    hash_dma_fetch i_hash_dma_fetch (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .src_addr(src_addr), .byte_cnt(byte_cnt),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_mask(out_mask), .out_last(out_last), .busy(busy), .dma_err(dma_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // Reference model state
    bit          m_busy = 0;
    bit          m_err = 0;
    bit          m_zero = 0;
    int          phase = 0;      // 0 may request, 1 awaiting response, 2 holding a word
    logic [31:0] m_addr = '0;
    longint      m_rem = 0;
    logic [3:0]  m_tail = '0;
    int          n_out = 0;
    int          n_req = 0;

    // Memory and sink behaviour controls
    int          rdy_mode = 0;
    bit          err_en = 0;
    bit          stop_on_err = 0;
    logic [31:0] err_addr = '0;
    int          pend = 0;
    logic [31:0] pend_addr = '0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
    endfunction

    function automatic logic [3:0] tail_of(input logic [31:0] n);
        case (n[1:0])
            2'd1:    return 4'b0001;
            2'd2:    return 4'b0011;
            2'd3:    return 4'b0111;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Cycle-by-cycle model: check, drive memory/sink, then advance
    always @(negedge clk) begin
        if (rst_n) begin
            bit          was_busy;
            bit          s;
            logic [3:0]  em;
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                finish_run();
            end
            // Output checks
            chk(busy === m_busy, "R8 busy", 32'(busy), 32'(m_busy));
            chk(dma_err === m_err, "R9 error flag", 32'(dma_err), 32'(m_err));
            if (!m_busy)
                chk(!mem_req_valid && !out_valid, "R10 idle outputs",
                    {30'd0, mem_req_valid, out_valid}, 32'd0);
            if (m_busy && mem_req_valid) begin
                chk(phase == 0, "R6 single outstanding read", 32'(phase), 32'd0);
                chk(m_rem > 0 && !m_zero, "R3 read count", 32'(n_req), 32'(m_rem));
                chk(mem_req_addr === m_addr, "R2 read address", mem_req_addr, m_addr);
            end
            if (m_busy && out_valid) begin
                if (m_zero) begin
                    chk(out_last === 1'b1 && out_mask === 4'b0000, "R5 empty beat",
                        {27'd0, out_last, out_mask}, 32'h10);
                end else begin
                    chk(phase == 2, "R6 beat only after response", 32'(phase), 32'd2);
                    chk(out_data === mem_word(m_addr), "R6 beat data", out_data, mem_word(m_addr));
                    em = (m_rem == 1) ? m_tail : 4'hF;
                    chk(out_mask === em, (m_rem == 1) ? "R4 tail mask" : "R3 full mask",
                        32'(out_mask), 32'(em));
                    chk(out_last === (m_rem == 1), "R4 last marker", 32'(out_last), 32'(m_rem == 1));
                end
            end
            // Drive inputs for the coming edge
            stop_drv      = 1'b0;
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(pend_addr);
                    mem_rsp_err   = err_en && (pend_addr == err_addr);
                    if (mem_rsp_err && stop_on_err) stop_drv = 1'b1;
                end
            end
            mem_req_ready = (rdy_mode == 0) ? 1'b1 : cyc[0];
            out_ready     = (rdy_mode == 0) ? 1'b1 : (cyc % 3 != 0);
            s = stop_t | stop_drv;
            // Advance the model over the coming edge
            was_busy = m_busy;
            if (m_busy && mem_req_valid && mem_req_ready) begin
                phase = 1; n_req++;
                pend = (rdy_mode == 0) ? 1 : 1 + (n_req % 3);
                pend_addr = mem_req_addr;
            end else if (m_busy && phase == 1 && mem_rsp_valid) begin
                if (mem_rsp_err) begin m_err = 1; m_busy = 0; phase = 0; end
                else phase = 2;
            end
            if (m_busy && out_valid && out_ready) begin
                n_out++;
                if (m_zero || m_rem == 1) m_busy = 0;
                else begin m_addr += 4; m_rem--; end
                phase = 0;
            end
            if (was_busy && s) begin m_busy = 0; phase = 0; end
            if (start && !was_busy) begin
                m_busy = 1; m_err = 0; phase = 0;
                m_addr = {src_addr[31:2], 2'b00};
                m_rem  = (longint'(byte_cnt) + 3) / 4;
                m_tail = tail_of(byte_cnt);
                m_zero = (byte_cnt == 0);
                n_out = 0; n_req = 0;
            end
        end
    end

    task automatic pulse_start(input logic [31:0] a, input logic [31:0] n);
        @(posedge clk); #2;
        src_addr = a; byte_cnt = n; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    task automatic wait_idle();
        @(posedge clk);
        while (m_busy) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    task automatic run_job(input logic [31:0] a, input logic [31:0] n, input string tag);
        pulse_start(a, n);
        wait_idle();
        chk(n_out == int'((longint'(n) + 3) / 4) || (n == 0 && n_out == 1), tag,
            32'(n_out), 32'((longint'(n) + 3) / 4));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !dma_err && !mem_req_valid && !out_valid, "R1 reset outputs",
            {28'd0, busy, dma_err, mem_req_valid, out_valid}, 32'd0);

        // R3/R4 whole words, then partial tails, with eager and stalling handshakes
        for (int mode = 0; mode < 2; mode++) begin
            rdy_mode = mode;
            run_job(32'h0000_1000, 32'd16, "R3 word count exact");
            run_job(32'h0000_2003, 32'd7,  "R2 R4 unaligned start, 3-byte tail");
            run_job(32'h0000_3000, 32'd1,  "R4 1-byte tail");
            run_job(32'h0000_3101, 32'd6,  "R4 2-byte tail");
            run_job(32'h0000_3202, 32'd9,  "R4 1-byte tail after two words");
        end

        // R5 zero count
        pulse_start(32'h0000_4000, 32'd0);
        wait_idle();
        chk(n_req == 0 && n_out == 1, "R5 no reads on zero count", 32'(n_req), 32'd0);

        // R7 inputs changed after start
        rdy_mode = 1;
        pulse_start(32'h0000_5000, 32'd20);
        src_addr = 32'h0000_9000; byte_cnt = 32'd3;
        wait_idle();
        chk(n_out == 5, "R7 latched count", 32'(n_out), 32'd5);

        // R8 start while busy ignored
        pulse_start(32'h0000_6000, 32'd24);
        repeat (5) @(posedge clk);
        pulse_start(32'h0000_7000, 32'd4);
        wait_idle();
        chk(n_out == 6, "R8 start while busy ignored", 32'(n_out), 32'd6);

        // R10 stop mid-job and stop while idle
        pulse_start(32'h0000_8000, 32'd40);
        repeat (9) @(posedge clk);
        #2 stop_t = 1'b1;
        @(posedge clk); #2 stop_t = 1'b0;
        repeat (2) @(posedge clk);
        chk(!busy && n_out < 10, "R10 stop aborts", 32'(n_out), 32'd10);
        repeat (8) @(posedge clk);
        #2 stop_t = 1'b1;
        @(posedge clk); #2 stop_t = 1'b0;
        run_job(32'h0000_8800, 32'd8, "R10 idle stop harmless");

        // R9 bus error, sticky until next start
        err_en = 1; err_addr = 32'h0000_A004;
        pulse_start(32'h0000_A000, 32'd20);
        wait_idle();
        chk(n_out == 1, "R9 no beat for faulting word", 32'(n_out), 32'd1);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(dma_err === 1'b1, "R9 flag sticky", 32'(dma_err), 32'd1);
        err_en = 0;
        run_job(32'h0000_B000, 32'd5, "R9 recovery job");
        @(negedge clk);
        chk(dma_err === 1'b0, "R9 flag cleared by start", 32'(dma_err), 32'd0);

        // R9 R10 stop together with an error response
        err_en = 1; stop_on_err = 1; err_addr = 32'h0000_C008;
        pulse_start(32'h0000_C000, 32'd32);
        wait_idle();
        @(negedge clk);
        chk(dma_err === 1'b1 && !busy, "R9 R10 stop with error", 32'(dma_err), 32'd1);
        err_en = 0; stop_on_err = 0;

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule